// File: doc/BRIEF.md
# Asynchronous Static Memory Bridge

This block connects a 32-bit host request port to a 16-bit asynchronous static memory such as an SRAM or a NOR flash. The host presents a byte address, write data, a transfer size and a direction, raises `req_valid`, and holds all of them steady until `req_ready` pulses. The bridge then produces the memory-side strobes: chip select, output enable, write enable, two active-low byte-lane enables, a halfword address and a bidirectional 16-bit data bus. All of these come from flops clocked by the system clock. That clock is never sent to the memory.

Each memory cycle goes through an address setup phase, a data phase and a hold phase, and each length is counted in clock cycles. Reads and writes can run from separate timing sets. A 32-bit host access becomes two memory cycles back to back. A byte access uses a single lane enable. A read result is latched on the final data-phase cycle, while chip select is still low.

Top module: `sram_bridge`

## Requirements
- R1: During reset and while idle, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_be_n` is 2'b11, `req_ready` is low, and the bridge does not drive the data bus.
- R2: A 16-bit access (`req_size`=1) makes a single memory cycle at halfword address `req_addr[ADDR_W-1:1]`. Both lane enables are low. A write stores `req_wdata[15:0]`. A read returns the halfword in `req_rdata[15:0]` with the upper bits at zero.
- R3: In each memory cycle `mem_cs_n` is low for exactly setup+data+hold clock cycles. `mem_we_n` (write) or `mem_oe_n` (read) is low for exactly the data-phase count. A setup or data value of 0 is treated as 1. A hold value of 0 removes the hold phase.
- R4: A 32-bit access (`req_size`=2) makes two memory cycles. The first uses halfword address {`req_addr[ADDR_W-1:2]`,0} and carries bits 15:0. The second uses the next halfword address and carries bits 31:16. `mem_cs_n` stays low from the start of the first cycle to the end of the second, and a read returns {second,first}.
- R5: A byte access (`req_size`=0) drives only `mem_be_n[0]` low when `req_addr[0]`=0, which selects data bits 7:0. It drives only `mem_be_n[1]` low when `req_addr[0]`=1, which selects bits 15:8. A write places `req_wdata[7:0]` on the selected lane. A read returns that lane's byte in `req_rdata[7:0]` with zeros above.
- R6: `req_ready` is high for exactly one cycle: the cycle right after the last memory cycle of the request ends. `req_rdata` is valid in that cycle. The start-to-ready count equals the total number of cycles with chip select low.
- R7: When `split_timing` is 1, writes use the `wr_*` durations and reads use the `rd_*` durations. When it is 0, every access uses the `rd_*` durations.
- R8: Read data is sampled on the last data-phase cycle, while `mem_cs_n` and `mem_oe_n` are still low. The result is correct even when the hold phase is 0.
- R9: The data bus is driven only during a write data phase. `mem_oe_n` and `mem_we_n` are never low together. `mem_oe_n` never goes low in the cycle after a driven cycle. All strobes are high in the `req_ready` cycle between host requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with req_ready |
| split_timing | input | 1 | Use separate write timing set |
| rd_setup | input | 4 | Read (or shared) setup cycles |
| rd_data | input | 8 | Read (or shared) data-phase cycles |
| rd_hold | input | 4 | Read (or shared) hold cycles |
| wr_setup | input | 4 | Write setup cycles |
| wr_data | input | 8 | Write data-phase cycles |
| wr_hold | input | 4 | Write hold cycles |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W-1 | Halfword address |
| mem_data | inout | 16 | Memory data bus |

## Verification
A request is raised at a falling edge. The bridge registers it at the next rising edge, and the strobes move at that same edge, so the bench sees chip select low at the next falling edge. The bench samples pins only at falling edges. It counts chip-select, output-enable and write-enable low cycles until it sees `req_ready`, and then compares those counts with setup+data+hold sums computed from the programmed values after applying the 0-to-1 clamp. The bench reads `req_rdata` in the same sampled cycle as `req_ready`. It reads the memory model's contents only after the request has completed.

// File: rtl/srb_pkg.sv
// Shared types for the static memory bridge: transfer size codes,
// access phases and one timing set.
package srb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_DATA  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [3:0] setup;
        logic [7:0] data;
        logic [3:0] hold;
    } timing_t;

endpackage

// File: rtl/srb_phase_timer.sv
// Down-counter for the length of the current phase.
// Assumes: load_val is the phase length minus one; done is high in the
// final cycle of the phase.
module srb_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Load at phase entry, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/srb_sequencer.sv
// Walks each memory cycle through setup, data and hold, chains the
// second half of a word access, and pulses ready when the request ends.
// Assumes: the host holds its request stable until ready.
module srb_sequencer
    import srb_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    input  logic [1:0] req_size,
    input  logic     split_timing,
    input  timing_t  rd_tim,
    input  timing_t  wr_tim,
    output phase_e   ph_nx,
    output logic     half_nx,
    output logic     half_q,
    output logic     last_data,
    output logic     ready_q
);
    phase_e        ph_q;
    timing_t       tsel;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          tmr_done;
    logic          end_half;
    logic          fin;
    logic [CW-1:0] setup_m1;
    logic [CW-1:0] data_m1;
    logic [CW-1:0] hold_m1;

    // Pick the timing set that governs this request.
    always_comb begin
        tsel = (req_write && split_timing) ? wr_tim : rd_tim;
    end

    // Convert lengths into counter loads, clamping setup and data to one.
    always_comb begin
        setup_m1 = (tsel.setup == 4'd0) ? '0 : CW'(tsel.setup) - 1'b1;
        data_m1  = (tsel.data == 8'd0)  ? '0 : CW'(tsel.data) - 1'b1;
        hold_m1  = (tsel.hold == 4'd0)  ? '0 : CW'(tsel.hold) - 1'b1;
    end

    srb_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (tmr_done)
    );

    // Next phase, half select and counter load.
    always_comb begin
        ph_nx    = ph_q;
        half_nx  = half_q;
        ld       = 1'b0;
        ld_val   = '0;
        end_half = 1'b0;
        fin      = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req_valid && !ready_q) begin
                    ph_nx   = PH_SETUP;
                    half_nx = 1'b0;
                    ld      = 1'b1;
                    ld_val  = setup_m1;
                end
            end
            PH_SETUP: begin
                if (tmr_done) begin
                    ph_nx  = PH_DATA;
                    ld     = 1'b1;
                    ld_val = data_m1;
                end
            end
            PH_DATA: begin
                if (tmr_done) begin
                    if (tsel.hold != 4'd0) begin
                        ph_nx  = PH_HOLD;
                        ld     = 1'b1;
                        ld_val = hold_m1;
                    end else begin
                        end_half = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (tmr_done) begin
                    end_half = 1'b1;
                end
            end
            default: ph_nx = PH_IDLE;
        endcase
        if (end_half) begin
            if ((req_size == SZ_WORD) && !half_q) begin
                ph_nx   = PH_SETUP;
                half_nx = 1'b1;
                ld      = 1'b1;
                ld_val  = setup_m1;
            end else begin
                ph_nx = PH_IDLE;
                fin   = 1'b1;
            end
        end
    end

    // Phase, half and ready registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            half_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            ph_q    <= ph_nx;
            half_q  <= half_nx;
            ready_q <= fin;
        end
    end

    assign last_data = (ph_q == PH_DATA) && tmr_done;

endmodule

// File: rtl/srb_pin_drive.sv
// Registers every memory-side pin from the next phase, so the pins
// change only on the clock edge. Also latches read data.
// Assumes: the data width is a whole number of byte lanes.
module srb_pin_drive
    import srb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            ph_nx,
    input  logic              half_nx,
    input  logic              half_q,
    input  logic              last_data,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [DW-1:0]     bus_in,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DW/8-1:0]   mem_be_n,
    output logic [ADDR_W-2:0] mem_addr,
    output logic              bus_oe,
    output logic [DW-1:0]     bus_out,
    output logic [31:0]       rdata,
    output logic              cap_en
);
    localparam int LANES = DW / 8;
    localparam int MAW   = ADDR_W - 1;

    logic             act_nx;
    logic [MAW-1:0]   ha_nx;
    logic [DW-1:0]    wd_nx;
    logic [LANES-1:0] lane_on;
    logic [7:0]       lane_byte [LANES];
    logic [7:0]       byte_rd;

    // Per-lane enable and read byte slice.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_on[l]   = (req_size != SZ_BYTE) || (req_addr[0] == 1'(l));
        assign lane_byte[l] = bus_in[8*l +: 8];
    end

    assign byte_rd = lane_byte[req_addr[0]];

    // Halfword address and write data for the half about to run.
    always_comb begin
        act_nx = (ph_nx != PH_IDLE);
        if (req_size == SZ_WORD) begin
            ha_nx = {req_addr[ADDR_W-1:2], half_nx};
            wd_nx = half_nx ? req_wdata[31:16] : req_wdata[15:0];
        end else if (req_size == SZ_HALF) begin
            ha_nx = req_addr[ADDR_W-1:1];
            wd_nx = req_wdata[15:0];
        end else begin
            ha_nx = req_addr[ADDR_W-1:1];
            wd_nx = {LANES{req_wdata[7:0]}};
        end
    end

    // Pin registers, derived from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_be_n <= '1;
            mem_addr <= '0;
            bus_oe   <= 1'b0;
            bus_out  <= '0;
        end else begin
            mem_cs_n <= !act_nx;
            mem_oe_n <= !((ph_nx == PH_DATA) && !req_write);
            mem_we_n <= !((ph_nx == PH_DATA) && req_write);
            bus_oe   <= (ph_nx == PH_DATA) && req_write;
            mem_be_n <= act_nx ? ~lane_on : '1;
            if (act_nx) begin
                mem_addr <= ha_nx;
                bus_out  <= wd_nx;
            end
        end
    end

    assign cap_en = last_data && !req_write;

    // Latch read data on the final data-phase cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cap_en) begin
            if (req_size == SZ_WORD) begin
                if (half_q) rdata[31:16] <= bus_in;
                else        rdata[15:0]  <= bus_in;
            end else if (req_size == SZ_HALF) begin
                rdata <= {16'h0000, bus_in};
            end else begin
                rdata <= {24'h000000, byte_rd};
            end
        end
    end

endmodule

// File: rtl/sram_bridge.sv
// Top of the bridge from a 32-bit host port to a 16-bit asynchronous
// static memory. It links the sequencer to the pin registers and owns
// the tristate bus.
// Assumes: the host holds the request stable from valid until ready.
module sram_bridge
    import srb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic [31:0]       req_rdata,
    input  logic              split_timing,
    input  logic [3:0]        rd_setup,
    input  logic [7:0]        rd_data,
    input  logic [3:0]        rd_hold,
    input  logic [3:0]        wr_setup,
    input  logic [7:0]        wr_data,
    input  logic [3:0]        wr_hold,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_be_n,
    output logic [ADDR_W-2:0] mem_addr,
    inout  wire  [15:0]       mem_data
);
    localparam int DW = 16;

    timing_t         rd_tim;
    timing_t         wr_tim;
    phase_e          ph_nx;
    logic            half_nx;
    logic            half_q;
    logic            last_data;
    logic            bus_oe;
    logic [DW-1:0]   bus_out;
    logic [DW-1:0]   bus_in;
    logic            cap_en;

    assign rd_tim = '{setup: rd_setup, data: rd_data, hold: rd_hold};
    assign wr_tim = '{setup: wr_setup, data: wr_data, hold: wr_hold};

    srb_sequencer #(.CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_size     (req_size),
        .split_timing (split_timing),
        .rd_tim       (rd_tim),
        .wr_tim       (wr_tim),
        .ph_nx        (ph_nx),
        .half_nx      (half_nx),
        .half_q       (half_q),
        .last_data    (last_data),
        .ready_q      (req_ready)
    );

    srb_pin_drive #(.ADDR_W(ADDR_W), .DW(DW)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_nx     (ph_nx),
        .half_nx   (half_nx),
        .half_q    (half_q),
        .last_data (last_data),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (bus_in),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_be_n  (mem_be_n),
        .mem_addr  (mem_addr),
        .bus_oe    (bus_oe),
        .bus_out   (bus_out),
        .rdata     (req_rdata),
        .cap_en    (cap_en)
    );

    assign mem_data = bus_oe ? bus_out : {DW{1'bz}};
    assign bus_in   = mem_data;

endmodule

// File: rtl/srb_checker.sv
// Protocol checks on the memory pins and host handshake, bound to
// the bridge top.
module srb_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [1:0]        mem_be_n,
    input logic [ADDR_W-2:0] mem_addr,
    input logic              bus_oe,
    input logic              cap_en,
    input logic              req_ready
);
    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n && mem_be_n == 2'b11)); // R1
    AST_HALF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n) && mem_addr != $past(mem_addr))
        |-> (mem_addr == $past(mem_addr) + 1'b1)); // R4
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R6
    AST_SAMPLE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (!mem_cs_n && !mem_oe_n)); // R8
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n); // R9
    AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !$past(bus_oe)); // R9
    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!mem_we_n && !mem_cs_n)); // R9
    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n); // R9
endmodule

bind sram_bridge srb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .mem_addr  (mem_addr),
    .bus_oe    (bus_oe),
    .cap_en    (cap_en),
    .req_ready (req_ready)
);

// File: tb/sram_bridge_tb.sv
// Directed bench: one task per scenario, with a behavioural 16-bit memory.
module sram_bridge_tb;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd1;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_ready;
    logic [31:0]       req_rdata;
    logic              split_timing = 1'b0;
    logic [3:0]        rd_setup = 4'd2;
    logic [7:0]        rd_data = 8'd3;
    logic [3:0]        rd_hold = 4'd1;
    logic [3:0]        wr_setup = 4'd1;
    logic [7:0]        wr_data = 8'd2;
    logic [3:0]        wr_hold = 4'd2;
    logic              mem_cs_n;
    logic              mem_oe_n;
    logic              mem_we_n;
    logic [1:0]        mem_be_n;
    logic [ADDR_W-2:0] mem_addr;
    wire  [15:0]       mem_data;

    int errors = 0;
    int checks = 0;

    // Results of the last access.
    int          n_cs, n_oe, n_we, n_fall, n_cyc, bad_excl, bad_turn;
    logic [1:0]  be_seen;
    logic [31:0] rd_res;
    logic        ready_cs;

    logic [15:0] mem [0:255];

    always #4 clk = ~clk;

    sram_bridge #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .split_timing(split_timing),
        .rd_setup(rd_setup), .rd_data(rd_data), .rd_hold(rd_hold),
        .wr_setup(wr_setup), .wr_data(wr_data), .wr_hold(wr_hold),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Memory model: drives on read, stores enabled lanes on write.
    assign mem_data = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 16'hzzzz;
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n) begin
            if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_data[7:0];
            if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] <= mem_data[15:8];
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host request; counts pin activity until ready.
    task automatic access(input logic wr, input logic [1:0] sz, input logic [ADDR_W-1:0] a, input logic [31:0] wd);
        logic prev_cs, prev_we, done;
        @(negedge clk);
        req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        n_cs = 0; n_oe = 0; n_we = 0; n_fall = 0; n_cyc = 0; bad_excl = 0; bad_turn = 0;
        be_seen = 2'b11; prev_cs = 1'b1; prev_we = 1'b1; done = 1'b0;
        while (!done) begin
            @(negedge clk);
            if (req_ready) begin
                done = 1'b1;
            end else begin
                n_cyc++;
                if (!mem_cs_n) begin n_cs++; be_seen = mem_be_n; end
                if (prev_cs && !mem_cs_n) n_fall++;
                if (!mem_oe_n) n_oe++;
                if (!mem_we_n) n_we++;
                if (!mem_oe_n && !mem_we_n) bad_excl++;
                if (!mem_oe_n && !prev_we) bad_turn++;
                prev_cs = mem_cs_n; prev_we = mem_we_n;
                if (n_cyc > 5000) begin
                    chk(1'b0, "R6 no ready", 32'(n_cyc), 32'd0);
                    done = 1'b1;
                end
            end
        end
        rd_res = req_rdata;
        ready_cs = mem_cs_n;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle", {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 32'd7);
        chk(mem_be_n == 2'b11, "R1 lanes idle", 32'(mem_be_n), 32'd3);
        chk(!req_ready, "R1 ready low", 32'(req_ready), 32'd0);
    endtask

    task automatic t_half();
        access(1'b1, 2'd1, 24'h000010, 32'hDEAD_A5C3);
        chk(mem[8] == 16'hA5C3, "R2 half write", 32'(mem[8]), 32'hA5C3);
        chk(be_seen == 2'b00, "R2 both lanes", 32'(be_seen), 32'd0);
        chk(n_cs == 6, "R3 cs cycles write", 32'(n_cs), 32'd6);
        chk(n_we == 3 && n_oe == 0, "R3 we cycles", 32'(n_we), 32'd3);
        chk(n_cyc == 6 && n_fall == 1, "R6 ready latency", 32'(n_cyc), 32'd6);
        access(1'b0, 2'd1, 24'h000010, 32'h0);
        chk(rd_res == 32'h0000A5C3, "R2 half read", rd_res, 32'h0000A5C3);
        chk(n_oe == 3 && n_we == 0, "R3 oe cycles", 32'(n_oe), 32'd3);
        chk(ready_cs, "R9 cs high at ready", 32'(ready_cs), 32'd1);
        chk(bad_turn == 0 && bad_excl == 0, "R9 bus turnaround", 32'(bad_turn + bad_excl), 32'd0);
    endtask

    task automatic t_word();
        access(1'b1, 2'd2, 24'h000020, 32'h1357_9BDF);
        chk(mem[16] == 16'h9BDF, "R4 low half first", 32'(mem[16]), 32'h9BDF);
        chk(mem[17] == 16'h1357, "R4 high half next", 32'(mem[17]), 32'h1357);
        chk(n_fall == 1, "R4 cs held across halves", 32'(n_fall), 32'd1);
        chk(n_cs == 12 && n_we == 6, "R3 split cycle count", 32'(n_cs), 32'd12);
        chk(n_cyc == 12, "R6 word ready latency", 32'(n_cyc), 32'd12);
        mem[18] = 16'h4444; mem[19] = 16'h8888;
        access(1'b0, 2'd2, 24'h000026, 32'h0);
        chk(rd_res == 32'h8888_4444, "R4 word read assembled", rd_res, 32'h88884444);
        chk(bad_turn == 0 && bad_excl == 0, "R9 word read bus", 32'(bad_turn + bad_excl), 32'd0);
    endtask

    task automatic t_byte();
        mem[5] = 16'h1122;
        access(1'b1, 2'd0, 24'h00000B, 32'h0000_00EE);
        chk(be_seen == 2'b01, "R5 odd lane strobe", 32'(be_seen), 32'd1);
        chk(mem[5] == 16'hEE22, "R5 odd byte write", 32'(mem[5]), 32'hEE22);
        access(1'b1, 2'd0, 24'h00000A, 32'h0000_0077);
        chk(be_seen == 2'b10, "R5 even lane strobe", 32'(be_seen), 32'd2);
        chk(mem[5] == 16'hEE77, "R5 even byte write", 32'(mem[5]), 32'hEE77);
        access(1'b0, 2'd0, 24'h00000B, 32'h0);
        chk(rd_res == 32'h0000_00EE, "R5 odd byte read", rd_res, 32'hEE);
        access(1'b0, 2'd0, 24'h00000A, 32'h0);
        chk(rd_res == 32'h0000_0077, "R5 even byte read", rd_res, 32'h77);
    endtask

    task automatic t_split();
        split_timing = 1'b1;
        access(1'b1, 2'd1, 24'h000030, 32'h0000_3C3C);
        chk(n_we == 2 && n_cs == 5, "R7 write set used", 32'(n_cs), 32'd5);
        access(1'b0, 2'd1, 24'h000030, 32'h0);
        chk(n_oe == 3 && n_cs == 6, "R7 read set kept", 32'(n_cs), 32'd6);
        chk(rd_res == 32'h0000_3C3C, "R7 data intact", rd_res, 32'h3C3C);
        split_timing = 1'b0;
        access(1'b1, 2'd1, 24'h000032, 32'h0000_5A5A);
        chk(n_we == 3 && n_cs == 6, "R7 shared set", 32'(n_cs), 32'd6);
    endtask

    task automatic t_hold0();
        rd_setup = 4'd0; rd_data = 8'd0; rd_hold = 4'd0;
        mem[40] = 16'hBEEF;
        access(1'b0, 2'd1, 24'h000050, 32'h0);
        chk(n_cs == 2 && n_oe == 1, "R3 clamp and zero hold", 32'(n_cs), 32'd2);
        chk(rd_res == 32'h0000_BEEF, "R8 sample before cs release", rd_res, 32'hBEEF);
        rd_setup = 4'd3; rd_data = 8'd4; rd_hold = 4'd0;
        access(1'b0, 2'd2, 24'h000050, 32'h0);
        chk(rd_res[15:0] == 16'hBEEF && n_cs == 14, "R8 word read no hold", rd_res, 32'hBEEF);
    endtask

    // Global watchdog.
    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_half();
        t_word();
        t_byte();
        t_split();
        t_hold0();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule